// File: doc/BRIEF.md
# Buck Regulator Enable and Fault Sequencer

This block is the state controller of a step-down switching regulator. It merges the hardware enable, setpoint-select and mode pins with two software enable bits and two mode bits, one of each per setpoint. From these it decides whether the power stage is off, running with automatic pulse-frequency modulation at light load, or running in forced PWM. It then walks the stage through soft-start into regulation and reports power-good and a compact status byte.

Its inputs are digital comparator flags for undervoltage, input overvoltage and over-temperature. It also takes a strobe that marks each switching cycle, with a flag that says whether that cycle reached the peak current limit. A run of consecutive current-limited cycles puts the stage into a timed hiccup pause before soft-start is tried again. An output-discharge pull-down is enabled whenever the configuration asks for it and the regulator is disabled. The soft-start time, the hiccup time and the current-limit run length are parameters, with times counted in system clock ticks.

Top module: `buck_seq_top`

## Requirements
- R1: The regulator is enabled when `enPin` is 1 and the software enable of the selected setpoint is 1 (`swEn0` while `vselPin` is 0, `swEn1` while it is 1). From the off state, switching (`swActive`) starts only when enabled and no fault flag is set.
- R2: `pwmForced` is 1 when `modePin` is 1. Otherwise it equals `modeBit0` while `vselPin` is 0 and `modeBit1` while `vselPin` is 1.
- R3: From the off state, enabled and fault-free at a clock edge, soft-start begins at that edge and lasts exactly `SOFT_TICKS` cycles. During soft-start `swActive`=1, `syncRectEn`=0 and `statusWord`=8'h19. Regulation follows.
- R4: In regulation `pgood`=1, `syncRectEn`=1, `swActive`=1 and, with no fault flag set, `statusWord`=8'h81.
- R5: A disable or any fault flag during soft-start or regulation returns the block to off at the next edge, clearing `pgood` and `swActive`.
- R6: `statusWord` bits are: 7 power-good, 6 `uvloFlag`, 5 `ovpFlag`, 4 and 3 soft-start in progress, 2 always 0, 1 `otFlag`, 0 stage enabled (soft-start or regulation). Bits 6, 5 and 1 follow their inputs in the same cycle.
- R7: `ILIM_RUN` consecutive `ilimStrobe` cycles with `ilimHit`=1, during soft-start or regulation, stop switching at the edge of the last one. A strobe with `ilimHit`=0 resets the run. Cycles without a strobe leave the run unchanged.
- R8: The hiccup pause lasts `HICCUP_TICKS` cycles, whatever the enable and fault inputs do meanwhile. It is followed by one off cycle, after which soft-start restarts if enabled.
- R9: `dischargeEn` equals `dischargeCfg` AND NOT enabled (R1), combinationally.
- R10: When a disable and the final current-limit strobe arrive at the same edge, the disable wins. The block goes to off, not to hiccup, and can restart at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enPin | input | 1 | Hardware enable pin |
| vselPin | input | 1 | Setpoint select pin |
| modePin | input | 1 | Forced-PWM pin |
| swEn0 | input | 1 | Software enable, setpoint 0 |
| swEn1 | input | 1 | Software enable, setpoint 1 |
| modeBit0 | input | 1 | Forced-PWM bit, setpoint 0 |
| modeBit1 | input | 1 | Forced-PWM bit, setpoint 1 |
| dischargeCfg | input | 1 | Allow output pull-down when disabled |
| uvloFlag | input | 1 | Input undervoltage comparator |
| ovpFlag | input | 1 | Input overvoltage comparator |
| otFlag | input | 1 | Over-temperature comparator |
| ilimStrobe | input | 1 | One pulse per switching cycle |
| ilimHit | input | 1 | The strobed cycle reached current limit |
| swActive | output | 1 | Power switches allowed to switch |
| syncRectEn | output | 1 | Synchronous rectifier allowed |
| pwmForced | output | 1 | 1 forced PWM, 0 automatic PFM |
| dischargeEn | output | 1 | Output pull-down enable |
| pgood | output | 1 | Power good |
| statusWord | output | 8 | Status byte, layout in R6 |

## Verification
A wrong state shows at once on `statusWord`, because its enable, soft-start and power-good bits encode the controller state in every cycle. A state register that is off by one in either timer shows as a soft-start or hiccup window one cycle too short or too long. The bench therefore counts those windows cycle by cycle. A current-limit counter that fails to reset, or that saturates early, shows as a stage that stops switching too soon or too late, measured in strobes.

// File: rtl/buck_seq_pkg.sv
`timescale 1ns/1ps
package buck_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_SOFT   = 2'd1,
    ST_RUN    = 2'd2,
    ST_HICCUP = 2'd3
  } seqState_t;

  typedef struct packed {
    logic loadSoft;
    logic loadHiccup;
    logic clearIlim;
  } dpCmd_t;
endpackage

// File: rtl/buck_seq_ctrl.sv
`timescale 1ns/1ps
module buck_seq_ctrl
  import buck_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enabled,
  input  logic      faultAny,
  input  logic      timerDone,
  input  logic      ilimTrip,
  output dpCmd_t    cmd,
  output seqState_t stateQ
);
  seqState_t stateD;
  logic active;

  assign active = (stateQ == ST_SOFT) || (stateQ == ST_RUN);

  always_comb begin
    stateD = stateQ;
    cmd = '0;
    cmd.clearIlim = !active;
    unique case (stateQ)
      ST_OFF: begin
        if (enabled && !faultAny) begin
          stateD = ST_SOFT;
          cmd.loadSoft = 1'b1;
        end
      end
      ST_SOFT, ST_RUN: begin
        if (!enabled || faultAny) begin
          stateD = ST_OFF;
        end else if (ilimTrip) begin
          stateD = ST_HICCUP;
          cmd.loadHiccup = 1'b1;
        end else if (stateQ == ST_SOFT && timerDone) begin
          stateD = ST_RUN;
        end
      end
      ST_HICCUP: begin
        if (timerDone) stateD = ST_OFF;
      end
      default: stateD = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_OFF;
    else       stateQ <= stateD;
  end

  logic inRun;
  assign inRun = (stateQ == ST_RUN);

  AST_HICCUP_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HICCUP && timerDone) |=> (stateQ == ST_OFF)); // R8
  AST_RUN_AFTER_SOFT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inRun) |-> ($past(stateQ) == ST_SOFT)); // R3
  AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (!enabled && active) |=> (stateQ == ST_OFF)); // R5
  AST_FAULT_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (faultAny && stateQ == ST_OFF) |=> (stateQ != ST_SOFT)); // R1
endmodule

// File: rtl/buck_seq_datapath.sv
`timescale 1ns/1ps
module buck_seq_datapath
  import buck_seq_pkg::*;
#(
  parameter int SOFT_TICKS   = 15000,
  parameter int HICCUP_TICKS = 340000,
  parameter int ILIM_RUN     = 16
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCmd_t cmd,
  input  logic   ilimStrobe,
  input  logic   ilimHit,
  output logic   timerDone,
  output logic   ilimTrip
);
  localparam int MaxTicks = (SOFT_TICKS > HICCUP_TICKS) ? SOFT_TICKS : HICCUP_TICKS;
  localparam int TimerW   = $clog2(MaxTicks + 1);
  localparam int IlimW    = (ILIM_RUN > 2) ? $clog2(ILIM_RUN) : 1;
  localparam logic [TimerW-1:0] SoftLoad   = TimerW'(SOFT_TICKS - 1);
  localparam logic [TimerW-1:0] HiccupLoad = TimerW'(HICCUP_TICKS - 1);
  localparam logic [IlimW-1:0]  IlimLast   = IlimW'(ILIM_RUN - 1);

  logic [TimerW-1:0] timerQ;
  logic [IlimW-1:0]  ilimCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                timerQ <= '0;
    else if (cmd.loadSoft)    timerQ <= SoftLoad;
    else if (cmd.loadHiccup)  timerQ <= HiccupLoad;
    else if (timerQ != '0)    timerQ <= timerQ - 1'b1;
  end

  assign timerDone = (timerQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN || cmd.clearIlim) ilimCnt <= '0;
    else if (ilimStrobe) begin
      if (!ilimHit)                ilimCnt <= '0;
      else if (ilimCnt != IlimLast) ilimCnt <= ilimCnt + 1'b1;
    end
  end

  assign ilimTrip = ilimStrobe && ilimHit && (ilimCnt == IlimLast);

  AST_ILIM_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (ilimCnt <= IlimLast)); // R7
  AST_MISS_RESETS: assert property (@(posedge clk) disable iff (!rstN)
    (ilimStrobe && !ilimHit) |=> (ilimCnt == '0)); // R7
  AST_HICCUP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadHiccup |=> !timerDone || (HICCUP_TICKS == 1)); // R8
endmodule

// File: rtl/buck_seq_top.sv
`timescale 1ns/1ps
module buck_seq_top
  import buck_seq_pkg::*;
#(
  parameter int SOFT_TICKS   = 15000,
  parameter int HICCUP_TICKS = 340000,
  parameter int ILIM_RUN     = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enPin,
  input  logic       vselPin,
  input  logic       modePin,
  input  logic       swEn0,
  input  logic       swEn1,
  input  logic       modeBit0,
  input  logic       modeBit1,
  input  logic       dischargeCfg,
  input  logic       uvloFlag,
  input  logic       ovpFlag,
  input  logic       otFlag,
  input  logic       ilimStrobe,
  input  logic       ilimHit,
  output logic       swActive,
  output logic       syncRectEn,
  output logic       pwmForced,
  output logic       dischargeEn,
  output logic       pgood,
  output logic [7:0] statusWord
);
  logic      enabled;
  logic      faultAny;
  logic      timerDone;
  logic      ilimTrip;
  logic      softActive;
  dpCmd_t    cmd;
  seqState_t stateQ;

  assign enabled  = enPin && (vselPin ? swEn1 : swEn0);
  assign faultAny = uvloFlag || ovpFlag || otFlag;

  buck_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enabled(enabled), .faultAny(faultAny),
    .timerDone(timerDone), .ilimTrip(ilimTrip), .cmd(cmd), .stateQ(stateQ)
  );

  buck_seq_datapath #(
    .SOFT_TICKS(SOFT_TICKS), .HICCUP_TICKS(HICCUP_TICKS), .ILIM_RUN(ILIM_RUN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .ilimStrobe(ilimStrobe),
    .ilimHit(ilimHit), .timerDone(timerDone), .ilimTrip(ilimTrip)
  );

  assign softActive  = (stateQ == ST_SOFT);
  assign pgood       = (stateQ == ST_RUN);
  assign swActive    = softActive || pgood;
  assign syncRectEn  = pgood;
  assign pwmForced   = modePin || (vselPin ? modeBit1 : modeBit0);
  assign dischargeEn = dischargeCfg && !enabled;
  assign statusWord  = {pgood, uvloFlag, ovpFlag, softActive, softActive,
                        1'b0, otFlag, swActive};

  AST_PGOOD_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |=> !pgood); // R5
  AST_FAULT_SILENCES: assert property (@(posedge clk) disable iff (!rstN)
    faultAny |=> !swActive); // R5
  AST_NO_DISCHARGE_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (dischargeEn && swActive) |=> !swActive); // R9
endmodule

// File: tb/buck_seq_top_tb.sv
`timescale 1ns/1ps
module buck_seq_top_tb;
  localparam int SS  = 20;
  localparam int HIC = 50;
  localparam int ILR = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enPin = 0, vselPin = 0, modePin = 0, swEn0 = 0, swEn1 = 0;
  logic modeBit0 = 0, modeBit1 = 0, dischargeCfg = 0;
  logic uvloFlag = 0, ovpFlag = 0, otFlag = 0, ilimStrobe = 0, ilimHit = 0;
  logic swActive, syncRectEn, pwmForced, dischargeEn, pgood;
  logic [7:0] statusWord;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  buck_seq_top #(.SOFT_TICKS(SS), .HICCUP_TICKS(HIC), .ILIM_RUN(ILR)) u_dut (
    .clk(clk), .rstN(rstN), .enPin(enPin), .vselPin(vselPin), .modePin(modePin),
    .swEn0(swEn0), .swEn1(swEn1), .modeBit0(modeBit0), .modeBit1(modeBit1),
    .dischargeCfg(dischargeCfg), .uvloFlag(uvloFlag), .ovpFlag(ovpFlag),
    .otFlag(otFlag), .ilimStrobe(ilimStrobe), .ilimHit(ilimHit),
    .swActive(swActive), .syncRectEn(syncRectEn), .pwmForced(pwmForced),
    .dischargeEn(dischargeEn), .pgood(pgood), .statusWord(statusWord)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic toRun();
    tick();
    repeat (SS) tick();
    chk("R4 status in regulation", statusWord, 8'h81);
  endtask

  task automatic strobes(input int n, input logic hit);
    for (int k = 0; k < n; k++) begin
      ilimStrobe = 1; ilimHit = hit;
      tick();
    end
    ilimStrobe = 0; ilimHit = 0;
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    chk("R6 reset status", statusWord, 8'h00);
    chk("R4 reset pgood", {7'b0, pgood}, 8'h00);

    // R1 R2 R9 sweep with a fault holding the block off
    uvloFlag = 1;
    for (int i = 0; i < 256; i++) begin
      logic en;
      logic pf;
      {enPin, vselPin, modePin, swEn0, swEn1, modeBit0, modeBit1, dischargeCfg} = 8'(i);
      #1;
      en = enPin & (vselPin ? swEn1 : swEn0);
      pf = modePin | (vselPin ? modeBit1 : modeBit0);
      chk("R2 mode select", {7'b0, pwmForced}, {7'b0, pf});
      chk("R9 discharge", {7'b0, dischargeEn}, {7'b0, dischargeCfg & ~en});
      tick();
      chk("R1 fault blocks start", {7'b0, swActive}, 8'h00);
      chk("R6 uvlo bit", statusWord, 8'h40);
    end
    {enPin, vselPin, modePin, swEn0, swEn1, modeBit0, modeBit1, dischargeCfg} = 8'h00;
    uvloFlag = 0;
    tick();

    // R1: disabled stays off
    enPin = 1; swEn1 = 1; vselPin = 0;
    repeat (3) tick();
    chk("R1 unselected enable ignored", {7'b0, swActive}, 8'h00);

    // R3 soft-start window
    swEn0 = 1;
    tick();
    for (int k = 0; k < SS; k++) begin
      chk("R3 soft-start status", statusWord, 8'h19);
      chk("R3 no sync rect", {7'b0, syncRectEn}, 8'h00);
      tick();
    end
    chk("R4 status", statusWord, 8'h81);
    chk("R4 sync rect", {7'b0, syncRectEn}, 8'h01);

    // R5/R6 faults
    ovpFlag = 1; #1;
    chk("R6 ovp bit live", statusWord, 8'hA1);
    tick();
    chk("R5 ovp stops", statusWord, 8'h20);
    ovpFlag = 0;
    toRun();
    otFlag = 1; #1;
    chk("R6 ot bit live", statusWord, 8'h83);
    tick();
    chk("R5 ot stops", statusWord, 8'h02);
    otFlag = 0;
    toRun();
    uvloFlag = 1;
    tick();
    chk("R5 uvlo stops", statusWord, 8'h40);
    uvloFlag = 0;
    toRun();

    // R5/R9 disable via setpoint select
    swEn1 = 0; dischargeCfg = 1; vselPin = 1; #1;
    chk("R9 discharge when disabled", {7'b0, dischargeEn}, 8'h01);
    tick();
    chk("R5 disable clears pgood", {7'b0, pgood}, 8'h00);
    chk("R5 disable stops", {7'b0, swActive}, 8'h00);
    vselPin = 0; dischargeCfg = 0;

    // R5 disable during soft-start
    repeat (5) tick();
    chk("R3 in soft-start", statusWord, 8'h19);
    enPin = 0;
    tick();
    chk("R5 disable in soft-start", statusWord, 8'h00);
    enPin = 1;
    toRun();

    // R7 current-limit run
    strobes(ILR - 1, 1);
    strobes(1, 0);
    strobes(ILR - 1, 1);
    repeat (3) tick();
    chk("R7 miss resets run", statusWord, 8'h81);
    strobes(1, 1);
    chk("R7 trip stops switching", {7'b0, swActive}, 8'h00);

    // R8 hiccup length with inputs toggling
    begin
      int zeros = 0;
      while (swActive == 1'b0 && zeros < 1000) begin
        if (zeros == 5) enPin = 0;
        if (zeros == 8) uvloFlag = 1;
        if (zeros == 10) begin enPin = 1; uvloFlag = 0; end
        tick();
        zeros++;
      end
      chk("R8 hiccup plus off cycles", 8'(zeros), 8'(HIC + 1));
      chk("R8 restart in soft-start", statusWord, 8'h19);
    end
    repeat (SS) tick();
    chk("R4 back in regulation", statusWord, 8'h81);

    // R10 disable beats trip
    strobes(ILR - 1, 1);
    enPin = 0; ilimStrobe = 1; ilimHit = 1;
    tick();
    ilimStrobe = 0; ilimHit = 0;
    chk("R10 off after tie", {7'b0, swActive}, 8'h00);
    enPin = 1;
    tick();
    chk("R10 restarts without hiccup", statusWord, 8'h19);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule